// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits between a simple memory-mapped register port and the raw pins of a NAND flash device. Software issues one flash bus cycle per register access. A write to the command register puts a byte on the flash I/O lines with the command latch enable raised. A write to the address register does the same with the address latch enable raised. A write or a read of the data register strobes write-enable or read-enable low once, with neither latch enable raised.

Each bus cycle has three phases: a setup phase, an active phase and a hold phase. Their lengths come from three fields of a configuration register. The port holds the requesting access with a wait signal until the cycle has ended, so software needs no polling for bus timing. A control word holds the controller-enable bit and the active-low chip-enable bit. A status register gives the synchronized level of the flash ready/busy pin.

Top module: `nfc_bus_ctrl`

## Requirements
- R1: A write to offset 0x08 drives the low byte of the write data on the flash I/O lines with output enable high. The command latch enable is high and the address latch enable is low for the whole cycle, and write-enable pulses low once.
- R2: A write to offset 0x0C drives its byte with the address latch enable high and the command latch enable low for the whole cycle, and write-enable pulses low once.
- R3: A write to offset 0x10 drives its byte with both latch enables low, output enable high and one write-enable pulse. Read-enable stays high.
- R4: A read of offset 0x10 pulses read-enable low once with output enable low. The access returns, in bits 7:0 with all upper bits zero, the flash byte present on the last cycle of the read-enable pulse.
- R5: The configuration register at offset 0x00 holds a setup count S in bits 14:12, an active count A in bits 10:8 and a hold count H in bits 6:4. Each phase lasts its count plus one clock cycles. Write-enable or read-enable is low only in the active phase, and a latch enable stays high across all three phases.
- R6: A flash cycle access holds the wait output high for S+A+H+4 cycles, counted from the first cycle the access is presented, and completes in the next cycle with wait low. No strobe is ever low while wait is low.
- R7: In the control register at offset 0x04, bit 0 enables the controller and bit 1 drives the chip-enable pin directly, where 1 deselects. The register reads back 0x2 after reset, and only a control write changes it.
- R8: While bit 0 of the control register is 0, accesses to offsets 0x08, 0x0C and 0x10 complete with no wait and no strobe, and a data read returns 0.
- R9: Bit 0 of the status register at offset 0x28 returns the ready/busy pin level, where 1 means ready, after a SYNC_STAGES-flop synchronizer. All other status bits read 0.
- R10: The configuration register reads back only its three count fields, with all other bits 0, and reads 0 after reset.
- R11: Accesses to unmapped offsets complete without wait and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, held until wait is low |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle wait is low |
| bus_wait | output | 1 | Stalls the current access |
| nand_dq_out | output | IO_W | Byte driven to the flash I/O lines |
| nand_dq_oe | output | 1 | Output enable for the flash I/O lines |
| nand_dq_in | input | IO_W | Byte read from the flash I/O lines |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rdy | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The sequencer is driven with a command write, an address write, a data write and a data read. Each uses a different setting of the three phase counts, including all zeros and all sevens. Together these separate a swapped or misplaced count field, an off-by-one phase length and a wrong latch enable. The bench counts, at the pins, the setup cycles before the strobe, the strobe width, the hold cycles after it and the wait length. It also records the byte present while the strobe is low and the byte returned on a read. Accesses made while the controller is disabled, and accesses to an unmapped offset, show that no bus cycle and no stall occur. The status read is taken right after the ready pin falls and again after the synchronizer delay, which exposes a wrong synchronizer depth.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;
   localparam int PH_W = 3;

   localparam logic [7:0] OFF_CFG  = 8'h00;
   localparam logic [7:0] OFF_CTRL = 8'h04;
   localparam logic [7:0] OFF_CMD  = 8'h08;
   localparam logic [7:0] OFF_ADR  = 8'h0C;
   localparam logic [7:0] OFF_DAT  = 8'h10;
   localparam logic [7:0] OFF_STAT = 8'h28;

   typedef enum logic [2:0] {
      PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD, PH_DONE
   } phase_e;

   typedef enum logic [1:0] {
      OP_CMD, OP_ADDR, OP_WDATA, OP_RDATA
   } op_e;

   typedef struct packed {
      logic [PH_W-1:0] setup;
      logic [PH_W-1:0] active;
      logic [PH_W-1:0] hold;
   } timing_t;
endpackage

// File: rtl/nfc_regs.sv
`timescale 1ns/1ps
module nfc_regs
   import nfc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wdata,
   output timing_t           tmg,
   output logic              ctl_en,
   output logic              ctl_ce_n,
   output logic [DATA_W-1:0] cfg_rd,
   output logic [DATA_W-1:0] ctrl_rd
);
   localparam int PAD_W = DATA_W - 16;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmg <= '0;
      end else if (cfg_wr) begin
         tmg.setup  <= wdata[14:12];
         tmg.active <= wdata[10:8];
         tmg.hold   <= wdata[6:4];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en   <= 1'b0;
         ctl_ce_n <= 1'b1;
      end else if (ctrl_wr) begin
         ctl_en   <= wdata[0];
         ctl_ce_n <= wdata[1];
      end
   end

   assign cfg_rd  = {{PAD_W{1'b0}}, 1'b0, tmg.setup, 1'b0, tmg.active,
                     1'b0, tmg.hold, 4'b0000};
   assign ctrl_rd = {{(DATA_W-2){1'b0}}, ctl_ce_n, ctl_en};

   // R7: control bits move only on a control write
   p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable({ctl_en, ctl_ce_n}));
endmodule

// File: rtl/nfc_rb_sync.sv
`timescale 1ns/1ps
module nfc_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] sr;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[0] <= 1'b0;
            else        sr[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[i] <= 1'b0;
            else        sr[i] <= sr[i-1];
         end
      end
   end

   assign dout = sr[STAGES-1];
endmodule

// File: rtl/nfc_seq.sv
`timescale 1ns/1ps
module nfc_seq
   import nfc_pkg::*;
#(
   parameter int IO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  op_e             op_in,
   input  logic [IO_W-1:0] byte_in,
   input  timing_t         tmg,
   input  logic [IO_W-1:0] dq_in,
   output logic [IO_W-1:0] dq_out,
   output logic            dq_oe,
   output logic            cle,
   output logic            ale,
   output logic            we_n,
   output logic            re_n,
   output logic            done,
   output logic            idle,
   output logic [IO_W-1:0] rd_byte
);
   phase_e          state;
   op_e             op_q;
   timing_t         tmg_q;
   logic [PH_W-1:0] cnt;
   logic            in_cyc;
   logic            last;

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PH_IDLE;
         op_q    <= OP_CMD;
         tmg_q   <= '0;
         cnt     <= '0;
         dq_out  <= '0;
         rd_byte <= '0;
      end else begin
         unique case (state)
            PH_IDLE: if (start) begin
               state  <= PH_SETUP;
               op_q   <= op_in;
               tmg_q  <= tmg;
               cnt    <= tmg.setup;
               dq_out <= byte_in;
            end
            PH_SETUP: if (last) begin
               state <= PH_ACTIVE;
               cnt   <= tmg_q.active;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_ACTIVE: if (last) begin
               state <= PH_HOLD;
               cnt   <= tmg_q.hold;
               if (op_q == OP_RDATA) rd_byte <= dq_in;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_HOLD: if (last) begin
               state <= PH_DONE;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_DONE: state <= PH_IDLE;
            default: state <= PH_IDLE;
         endcase
      end
   end

   assign in_cyc = (state == PH_SETUP) || (state == PH_ACTIVE) || (state == PH_HOLD);
   assign cle    = in_cyc && (op_q == OP_CMD);
   assign ale    = in_cyc && (op_q == OP_ADDR);
   assign dq_oe  = in_cyc && (op_q != OP_RDATA);
   assign we_n   = !((state == PH_ACTIVE) && (op_q != OP_RDATA));
   assign re_n   = !((state == PH_ACTIVE) && (op_q == OP_RDATA));
   assign done   = (state == PH_DONE);
   assign idle   = (state == PH_IDLE);

   // R1: the two latch enables are never high together
   p_latch_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   // R3: the two strobes are never low together
   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   // R5: a strobe falls only after a setup phase
   p_setup_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(we_n) || $fell(re_n)) |-> ($past(state) == PH_SETUP));
   // R1: write data is driven while write-enable is low
   p_oe_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> dq_oe);
endmodule

// File: rtl/nfc_bus_ctrl.sv
`timescale 1ns/1ps
module nfc_bus_ctrl
   import nfc_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int IO_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_wait,
   output logic [IO_W-1:0]   nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [IO_W-1:0]   nand_dq_in,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_ce_n,
   output logic              nand_we_n,
   output logic              nand_re_n,
   input  logic              nand_rdy
);
   if (IO_W < 8 || IO_W > 16) begin : g_bad_io
      $error("IO_W must lie in 8..16");
   end
   if (DATA_W < 16 || DATA_W < IO_W) begin : g_bad_data
      $error("DATA_W must be at least 16 and at least IO_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   localparam int RD_PAD = DATA_W - IO_W;

   logic hit_cfg, hit_ctrl, hit_cmd, hit_adr, hit_dat, hit_stat, hit_flash;
   logic ctl_en, ctl_ce_n, rdy_s, done, idle, start;
   logic [DATA_W-1:0] cfg_rd, ctrl_rd, dat_rd;
   logic [IO_W-1:0]   rd_byte;
   timing_t           tmg;
   op_e               op_sel;
   logic              unused_wd;

   assign hit_cfg   = bus_addr == ADDR_W'(OFF_CFG);
   assign hit_ctrl  = bus_addr == ADDR_W'(OFF_CTRL);
   assign hit_cmd   = bus_addr == ADDR_W'(OFF_CMD);
   assign hit_adr   = bus_addr == ADDR_W'(OFF_ADR);
   assign hit_dat   = bus_addr == ADDR_W'(OFF_DAT);
   assign hit_stat  = bus_addr == ADDR_W'(OFF_STAT);
   assign hit_flash = (hit_dat || ((hit_cmd || hit_adr) && bus_wr)) && ctl_en;
   assign unused_wd = ^bus_wdata;

   always_comb begin
      if (hit_cmd)      op_sel = OP_CMD;
      else if (hit_adr) op_sel = OP_ADDR;
      else if (bus_wr)  op_sel = OP_WDATA;
      else              op_sel = OP_RDATA;
   end

   assign start    = bus_sel && hit_flash && idle;
   assign bus_wait = bus_sel && hit_flash && !done;

   nfc_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (bus_sel && bus_wr && hit_cfg),
      .ctrl_wr  (bus_sel && bus_wr && hit_ctrl),
      .wdata    (bus_wdata),
      .tmg      (tmg),
      .ctl_en   (ctl_en),
      .ctl_ce_n (ctl_ce_n),
      .cfg_rd   (cfg_rd),
      .ctrl_rd  (ctrl_rd)
   );

   nfc_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (nand_rdy),
      .dout  (rdy_s)
   );

   nfc_seq #(.IO_W(IO_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .op_in   (op_sel),
      .byte_in (bus_wdata[IO_W-1:0]),
      .tmg     (tmg),
      .dq_in   (nand_dq_in),
      .dq_out  (nand_dq_out),
      .dq_oe   (nand_dq_oe),
      .cle     (nand_cle),
      .ale     (nand_ale),
      .we_n    (nand_we_n),
      .re_n    (nand_re_n),
      .done    (done),
      .idle    (idle),
      .rd_byte (rd_byte)
   );

   if (RD_PAD > 0) begin : g_pad
      assign dat_rd = ctl_en ? {{RD_PAD{1'b0}}, rd_byte} : '0;
   end else begin : g_nopad
      assign dat_rd = ctl_en ? rd_byte : '0;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_cfg)       bus_rdata = cfg_rd;
      else if (hit_ctrl) bus_rdata = ctrl_rd;
      else if (hit_stat) bus_rdata = {{(DATA_W-1){1'b0}}, rdy_s};
      else if (hit_dat)  bus_rdata = dat_rd;
   end

   assign nand_ce_n = ctl_ce_n;

   // R6: strobes only while the requesting access is stalled
   p_strobe_in_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> bus_wait);
   // R8: a disabled controller keeps both strobes high
   p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> (nand_we_n && nand_re_n));
endmodule

// File: tb/nfc_bus_ctrl_tb.sv
`timescale 1ns/1ps
module nfc_bus_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_wait;
   logic [7:0]  dq_out, dq_in, flash_byte = 8'h00;
   logic        dq_oe, cle, ale, ce_n, we_n, re_n;
   logic        rdy = 1'b1;
   int          n_run = 0, n_fail = 0;
   bit          finished = 1'b0;

   int c_wait, c_cle, c_ale, c_we, c_re, c_oe, c_pre, c_post;
   logic [7:0] seen_byte;
   bit bad_mix, bad_lat;

   always #4 clk = ~clk;
   assign dq_in = re_n ? 8'h00 : flash_byte;

   nfc_bus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_wait(bus_wait), .nand_dq_out(dq_out), .nand_dq_oe(dq_oe),
      .nand_dq_in(dq_in), .nand_cle(cle), .nand_ale(ale), .nand_ce_n(ce_n),
      .nand_we_n(we_n), .nand_re_n(re_n), .nand_rdy(rdy)
   );

   task automatic chk(input string req, input string what, input longint got, input longint exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                         output logic [31:0] q);
      bit strobe_seen;
      int guard;
      c_wait = 0; c_cle = 0; c_ale = 0; c_we = 0; c_re = 0; c_oe = 0;
      c_pre = 0; c_post = 0; seen_byte = 8'h00; bad_mix = 0; bad_lat = 0;
      strobe_seen = 0; guard = 0;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      #1;
      while (bus_wait && guard < 200) begin
         c_wait++;
         if (cle) c_cle++;
         if (ale) c_ale++;
         if (dq_oe) c_oe++;
         if (cle && ale) bad_mix = 1;
         if (!we_n || !re_n) begin
            strobe_seen = 1;
            if (!(cle || ale) && (c_cle + c_ale) != 0) bad_lat = 1;
         end else if (strobe_seen) c_post++;
         else c_pre++;
         if (!we_n) begin c_we++; seen_byte = dq_out; end
         if (!re_n) c_re++;
         guard++;
         @(negedge clk); #1;
      end
      if (guard >= 200) chk("R6", "stall bounded", 1, 0);
      if (!we_n || !re_n) bad_lat = 1;
      q = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] q;
      #1;
      chk("R7", "ce_n at reset", ce_n, 1);
      chk("R1", "cle/ale at reset", {cle, ale}, 0);
      chk("R5", "strobes at reset", {we_n, re_n}, 2'b11);
      access(0, 8'h04, 0, q); chk("R7", "control reset value", q, 32'h2);
      access(0, 8'h00, 0, q); chk("R10", "config reset value", q, 0);
      chk("R6", "register read no wait", c_wait, 0);
   endtask

   task automatic t_disabled();
      logic [31:0] q;
      access(1, 8'h08, 32'h77, q);
      chk("R8", "disabled cmd wait", c_wait, 0);
      chk("R8", "disabled cmd strobes", c_we + c_re + c_cle, 0);
      #2; chk("R8", "disabled we_n pin", we_n, 1);
      access(0, 8'h10, 0, q);
      chk("R8", "disabled data read value", q, 0);
      chk("R8", "disabled read wait", c_wait, 0);
   endtask

   task automatic t_enable();
      logic [31:0] q;
      access(1, 8'h04, 32'h1, q);
      access(0, 8'h04, 0, q);
      chk("R7", "control readback", q, 32'h1);
      #2; chk("R7", "chip selected", ce_n, 0);
   endtask

   task automatic t_config();
      logic [31:0] q;
      access(1, 8'h00, 32'hFFFF_FFFF, q);
      access(0, 8'h00, 0, q);
      chk("R10", "config field mask", q, 32'h7770);
   endtask

   task automatic t_cmd();
      logic [31:0] q;
      access(1, 8'h00, 32'h1200, q);  // S=1 A=2 H=0
      access(1, 8'h08, 32'hFFFF_FF5A, q);
      chk("R1", "cmd byte", seen_byte, 8'h5A);
      chk("R1", "cmd cle cycles", c_cle, 1 + 2 + 0 + 3);
      chk("R1", "cmd ale cycles", c_ale, 0);
      chk("R1", "cmd latch mix", bad_mix, 0);
      chk("R5", "cmd setup", c_pre, 1 + 2);
      chk("R5", "cmd active", c_we, 2 + 1);
      chk("R5", "cmd hold", c_post, 0 + 1);
      chk("R5", "latch held around strobe", bad_lat, 0);
      chk("R6", "cmd wait", c_wait, 1 + 2 + 0 + 4);
   endtask

   task automatic t_addr();
      logic [31:0] q;
      access(1, 8'h00, 32'h0000, q);  // all phases one cycle
      access(1, 8'h0C, 32'h0000_00C3, q);
      chk("R2", "addr byte", seen_byte, 8'hC3);
      chk("R2", "addr ale cycles", c_ale, 3);
      chk("R2", "addr cle cycles", c_cle, 0);
      chk("R2", "addr we width", c_we, 1);
      chk("R6", "addr wait", c_wait, 4);
   endtask

   task automatic t_wdata();
      logic [31:0] q;
      access(1, 8'h00, 32'h7770, q);
      access(1, 8'h10, 32'h0000_00A5, q);
      chk("R3", "data byte", seen_byte, 8'hA5);
      chk("R3", "data latches", c_cle + c_ale, 0);
      chk("R3", "data re unused", c_re, 0);
      chk("R3", "data oe cycles", c_oe, 24);
      chk("R5", "max setup", c_pre, 9);
      chk("R5", "max active", c_we, 8);
      chk("R5", "max hold", c_post, 8);
      chk("R6", "max wait", c_wait, 25);
   endtask

   task automatic t_rdata();
      logic [31:0] q;
      access(1, 8'h00, 32'h2310, q);  // S=2 A=3 H=1
      flash_byte = 8'h96;
      access(0, 8'h10, 0, q);
      chk("R4", "read value", q, 32'h96);
      chk("R4", "read re width", c_re, 4);
      chk("R4", "read we unused", c_we, 0);
      chk("R4", "read oe off", c_oe, 0);
      chk("R5", "read setup", c_pre, 4);
      chk("R5", "read hold", c_post, 2);
      chk("R6", "read wait", c_wait, 10);
   endtask

   task automatic t_status();
      logic [31:0] q;
      access(0, 8'h28, 0, q);
      chk("R9", "ready level", q, 1);
      @(negedge clk); rdy = 1'b0;
      #1;
      chk("R9", "before sync delay", bus_rdata_peek(), 1);
      repeat (3) @(negedge clk);
      access(0, 8'h28, 0, q);
      chk("R9", "busy level", q, 0);
      rdy = 1'b1;
      repeat (3) @(negedge clk);
      access(0, 8'h28, 0, q);
      chk("R9", "ready again", q, 1);
   endtask

   function automatic logic [31:0] bus_rdata_peek();
      return bus_rdata;
   endfunction

   task automatic t_unmapped_and_deselect();
      logic [31:0] q;
      access(0, 8'h3C, 0, q);
      chk("R11", "unmapped read", q, 0);
      chk("R11", "unmapped wait", c_wait, 0);
      access(1, 8'h04, 32'h3, q);
      access(0, 8'h04, 0, q);
      chk("R7", "deselect readback", q, 32'h3);
      #2; chk("R7", "chip deselected", ce_n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_disabled();
      t_enable();
      t_config();
      t_cmd();
      t_addr();
      t_wdata();
      t_rdata();
      bus_addr = 8'h28;
      t_status();
      t_unmapped_and_deselect();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule